// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external host reach a small bank of 16-bit registers over a four-wire serial link. The clock idles high and data is captured on the rising edge, so the clock polarity and phase settings are both 1. Every transfer is exactly sixteen clocks long. A frame either writes one byte into a configuration register, or names a register whose full 16-bit word the block sends back during the next frame. Because the host always shifts a new command in while the previous answer is shifted out, a stream of reads runs at one word per frame with a one-frame lag.

The serial pins are brought into the system clock domain through two-flop synchronizers. All decoding, register updates and side effects then happen as single-cycle strobes in that domain. The bank holds three kinds of location. Sampled output words are loaded by a sample strobe and carry a new-data flag and an error flag. A status word gathers sticky flags and clears when it is read. Configuration words can be written one byte at a time and are visible as a flat output bus. Reads have side effects: reading any output word clears the shared new-data flag, and reading the status word clears it. A frame cut short by chip select is thrown away and recorded as a link failure.

Top module: `spi_regport`

## Requirements
- R1: A frame runs while cs_n_i is low. sclk_i idles high and mosi_i is sampled on each rising edge of sclk_i. Sixteen edges make a frame, sent MSB first. Bit 15 selects the direction (1 = write, 0 = read). Bit 14 is ignored. Bits 13:8 hold the byte address and bits 7:0 hold the write data. The data bits have no effect in a read frame.
- R2: Configuration word k (k = 0..3) occupies byte addresses 0x20+2k (bits 7:0) and 0x21+2k (bits 15:8) and appears on cfg_o[16k+15:16k]. A completed write frame to one of these addresses changes only that byte.
- R3: After a completed read frame, the next frame shifts the addressed 16-bit word out on miso_o, MSB first. Each bit is presented after a falling edge of sclk_i, so the host samples it on the following rising edge. A read of an odd byte address returns the 16-bit word that contains it.
- R4: The frame that follows a write frame, an aborted frame or reset shifts out all zeros.
- R5: Output word k (k = 0..3, byte address 2k) reads as {new-data flag, error flag, 14 data bits}. The error flag is 1 when any status bit is set at the time of the read. The data bits are smp_data_i[14k+13:14k] as captured at the last smp_valid_i strobe. Word 3 holds 12-bit data, so its bits 13:12 always read 0.
- R6: The new-data flag is shared by all output words. A strobe on smp_valid_i sets it. A completed read of any output word clears it. If a sample and such a read land in the same cycle, the flag stays set.
- R7: The status word sits at byte address 0x10. A strobe on smp_valid_i ORs status_set_i into it. A completed read returns the word and then clears every bit. A flag raised in the same cycle as the clearing read is kept.
- R8: When cs_n_i rises before sixteen rising edges have been received, the frame causes no write and no read side effect, and status bit 3 is set.
- R9: Writes to any address outside the configuration words change nothing. Reads of addresses that map to no register return 0.
- R10: After reset, miso_o is 0, every configuration word is 0, the status word is 0 and the new-data flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| cs_n_i | input | 1 | Active-low frame select from the host |
| mosi_i | input | 1 | Serial command and data from the host |
| miso_o | output | 1 | Serial response to the host |
| smp_valid_i | input | 1 | One-cycle strobe marking a new internal sample |
| smp_data_i | input | NUM_OUT*14 | Sample data, 14 bits per output word |
| status_set_i | input | 16 | Status conditions ORed in on a sample strobe |
| cfg_o | output | NUM_CFG*16 | Configuration words, packed |

## Verification
Internal state has no direct window, so a wrong value only shows up at the ports. A corrupted shift count or decode shows up as a wrong byte on cfg_o one cycle after the sixteenth rising edge, or as a wrong word on miso_o one whole frame later. A flag that failed to clear, or cleared when it should not, stays hidden until the next read of an output word or the status word returns it. The bench therefore follows every read with a further frame and compares each bit against an independent model of the flags, including partial frames and reads at odd and unmapped addresses.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 6;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 16;
    localparam int DATA_W     = 14;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int WIDX_W     = ADDR_W - 1;

    typedef logic [WORD_W-1:0] word_t;

    // decoded command, reserved bit already dropped
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } frame_t;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_OUT,
        RG_STAT,
        RG_CFG
    } region_e;

    function automatic region_e region_of(
        input logic [ADDR_W-1:0] a,
        input int                n_out,
        input int                stat_w,
        input int                cfg_b,
        input int                n_cfg
    );
        int w;
        w = int'(a[ADDR_W-1:1]);
        if (w < n_out)                        return RG_OUT;
        if (w == stat_w)                      return RG_STAT;
        if ((w >= cfg_b) && (w < cfg_b + n_cfg)) return RG_CFG;
        return RG_NONE;
    endfunction

    function automatic word_t tag_word(
        input logic              nd,
        input logic              ea,
        input logic [DATA_W-1:0] d
    );
        return {nd, ea, d};
    endfunction

endpackage

// File: rtl/spi_rx_frontend.sv
module spi_rx_frontend
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_i,
    input  logic   cs_n_i,
    input  logic   mosi_i,
    output logic   cs_fall_o,
    output logic   sclk_fall_o,
    output logic   frame_done_o,
    output frame_t frame_o,
    output logic   abort_o
);

    logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
    logic                   sclk_d, cs_d;
    logic                   sclk_s, cs_s, mosi_s;
    logic                   active, sclk_rise, cs_rise;
    logic [CNT_W-1:0]       cnt_q;
    logic [FRAME_BITS-1:0]  sh_q;
    logic                   done_q, abort_q;

    assign sclk_s = sclk_q[SYNC_STAGES-1];
    assign cs_s   = cs_q[SYNC_STAGES-1];
    assign mosi_s = mosi_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '1;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b1;
            cs_d   <= 1'b1;
        end else begin
            sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk_i};
            cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n_i};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi_i};
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
        end
    end

    assign active      = ~cs_s;
    assign sclk_rise   = active & sclk_s & ~sclk_d;
    assign sclk_fall_o = active & ~sclk_s & sclk_d;
    assign cs_fall_o   = ~cs_s & cs_d;
    assign cs_rise     = cs_s & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            if (cs_fall_o) begin
                cnt_q <= '0;
            end else if (sclk_rise && (cnt_q != CNT_W'(FRAME_BITS))) begin
                sh_q  <= {sh_q[FRAME_BITS-2:0], mosi_s};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                    done_q <= 1'b1;
                end
            end
            if (cs_rise && (cnt_q != CNT_W'(FRAME_BITS))) begin
                abort_q <= 1'b1;
            end
        end
    end

    assign frame_done_o = done_q;
    assign abort_o      = abort_q;
    assign frame_o      = '{wr:   sh_q[FRAME_BITS-1],
                            addr: sh_q[ADDR_W+BYTE_W-1:BYTE_W],
                            data: sh_q[BYTE_W-1:0]};

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
    import spi_regport_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_fall_i,
    input  logic  sclk_fall_i,
    input  word_t load_word_i,
    output logic  miso_o
);

    word_t sh_q;
    logic  miso_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            miso_q <= 1'b0;
        end else if (cs_fall_i) begin
            sh_q <= load_word_i;
        end else if (sclk_fall_i) begin
            miso_q <= sh_q[WORD_W-1];
            sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign miso_o = miso_q;

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done_i,
    input  frame_t            frame_i,
    input  logic              cs_fall_i,
    input  word_t             rd_data_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output word_t             tx_word_o
);

    word_t tx_q;

    assign wr_stb_o  = frame_done_i & frame_i.wr;
    assign rd_stb_o  = frame_done_i & ~frame_i.wr;
    assign wr_addr_o = frame_i.addr;
    assign wr_data_o = frame_i.data;
    assign rd_addr_o = frame_i.addr;

    // the pending answer is consumed by each new frame
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (cs_fall_i) begin
            tx_q <= '0;
        end else if (rd_stb_o) begin
            tx_q <= rd_data_i;
        end
    end

    assign tx_word_o = tx_q;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regport_pkg::*;
#(
    parameter int                 NUM_OUT      = 4,
    parameter int                 NUM_CFG      = 4,
    parameter int                 STAT_WORD    = 8,
    parameter int                 CFG_BASE     = 16,
    parameter logic [NUM_OUT-1:0] NARROW_MASK  = 4'b1000,
    parameter int                 SPI_FAIL_BIT = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        smp_valid_i,
    input  logic [NUM_OUT*DATA_W-1:0]   smp_data_i,
    input  word_t                       status_set_i,
    input  logic                        spi_fail_i,
    input  logic                        wr_stb_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [BYTE_W-1:0]           wr_data_i,
    input  logic                        rd_stb_i,
    input  logic [ADDR_W-1:0]           rd_addr_i,
    output word_t                       rd_data_o,
    output logic [NUM_CFG*WORD_W-1:0]   cfg_o,
    output logic                        nd_o,
    output word_t                       status_o
);

    function automatic logic [NUM_OUT*DATA_W-1:0] build_keep();
        logic [NUM_OUT*DATA_W-1:0] r;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (NARROW_MASK[i]) r[i*DATA_W +: DATA_W] = {2'b00, {(DATA_W-2){1'b1}}};
            else                r[i*DATA_W +: DATA_W] = '1;
        end
        return r;
    endfunction

    localparam logic [NUM_OUT*DATA_W-1:0] KEEP      = build_keep();
    localparam word_t                     FAIL_MASK = word_t'(1) << SPI_FAIL_BIT;

    logic [NUM_OUT*DATA_W-1:0] out_q;
    logic                      nd_q;
    word_t                     stat_q;
    word_t                     cfg_q    [NUM_CFG];
    word_t                     out_word [NUM_OUT];
    logic                      ea;
    region_e                   rd_rg, wr_rg;
    logic [WIDX_W-1:0]         rd_w, wr_w;
    logic                      rd_out, rd_stat;

    assign rd_w    = rd_addr_i[ADDR_W-1:1];
    assign wr_w    = wr_addr_i[ADDR_W-1:1];
    assign rd_rg   = region_of(rd_addr_i, NUM_OUT, STAT_WORD, CFG_BASE, NUM_CFG);
    assign wr_rg   = region_of(wr_addr_i, NUM_OUT, STAT_WORD, CFG_BASE, NUM_CFG);
    assign rd_out  = rd_stb_i && (rd_rg == RG_OUT);
    assign rd_stat = rd_stb_i && (rd_rg == RG_STAT);
    assign ea      = |stat_q;

    // sampled output words
    always_ff @(posedge clk) begin
        if (rst)              out_q <= '0;
        else if (smp_valid_i) out_q <= smp_data_i & KEEP;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        assign out_word[g] = tag_word(nd_q, ea, out_q[g*DATA_W +: DATA_W]);
    end

    // shared new-data flag, sample has priority over the clearing read
    always_ff @(posedge clk) begin
        if (rst)              nd_q <= 1'b0;
        else if (smp_valid_i) nd_q <= 1'b1;
        else if (rd_out)      nd_q <= 1'b0;
    end

    // sticky status, new flags win over the clearing read
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (rd_stat ? word_t'(0) : stat_q)
                    | (smp_valid_i ? status_set_i : word_t'(0))
                    | (spi_fail_i ? FAIL_MASK : word_t'(0));
        end
    end

    // byte-granular configuration storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CFG; i++) cfg_q[i] <= '0;
        end else if (wr_stb_i && (wr_rg == RG_CFG)) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (wr_w == WIDX_W'(CFG_BASE + i)) begin
                    if (wr_addr_i[0]) cfg_q[i][WORD_W-1:BYTE_W] <= wr_data_i;
                    else              cfg_q[i][BYTE_W-1:0]      <= wr_data_i;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        assign cfg_o[g*WORD_W +: WORD_W] = cfg_q[g];
    end

    // read path
    always_comb begin
        rd_data_o = '0;
        unique case (rd_rg)
            RG_OUT: begin
                for (int i = 0; i < NUM_OUT; i++) begin
                    if (rd_w == WIDX_W'(i)) rd_data_o = out_word[i];
                end
            end
            RG_STAT: rd_data_o = stat_q;
            RG_CFG: begin
                for (int i = 0; i < NUM_CFG; i++) begin
                    if (rd_w == WIDX_W'(CFG_BASE + i)) rd_data_o = cfg_q[i];
                end
            end
            default: rd_data_o = '0;
        endcase
    end

    assign nd_o     = nd_q;
    assign status_o = stat_q;

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int                 NUM_OUT      = 4,
    parameter int                 NUM_CFG      = 4,
    parameter int                 STAT_WORD    = 8,
    parameter int                 CFG_BASE     = 16,
    parameter logic [NUM_OUT-1:0] NARROW_MASK  = 4'b1000,
    parameter int                 SPI_FAIL_BIT = 3,
    parameter int                 SYNC_STAGES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sclk_i,
    input  logic                      cs_n_i,
    input  logic                      mosi_i,
    output logic                      miso_o,
    input  logic                      smp_valid_i,
    input  logic [NUM_OUT*DATA_W-1:0] smp_data_i,
    input  logic [WORD_W-1:0]         status_set_i,
    output logic [NUM_CFG*WORD_W-1:0] cfg_o
);

    logic              cs_fall, sclk_fall, frame_done, abort_pulse;
    frame_t            frame;
    logic              wr_stb, rd_stb;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [BYTE_W-1:0] wr_data;
    word_t             rd_data, tx_word, status_word;
    logic              nd_flag;

    spi_rx_frontend #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk_i),
        .cs_n_i       (cs_n_i),
        .mosi_i       (mosi_i),
        .cs_fall_o    (cs_fall),
        .sclk_fall_o  (sclk_fall),
        .frame_done_o (frame_done),
        .frame_o      (frame),
        .abort_o      (abort_pulse)
    );

    spi_frame_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .frame_done_i (frame_done),
        .frame_i      (frame),
        .cs_fall_i    (cs_fall),
        .rd_data_i    (rd_data),
        .wr_stb_o     (wr_stb),
        .wr_addr_o    (wr_addr),
        .wr_data_o    (wr_data),
        .rd_stb_o     (rd_stb),
        .rd_addr_o    (rd_addr),
        .tx_word_o    (tx_word)
    );

    spi_reg_bank #(
        .NUM_OUT      (NUM_OUT),
        .NUM_CFG      (NUM_CFG),
        .STAT_WORD    (STAT_WORD),
        .CFG_BASE     (CFG_BASE),
        .NARROW_MASK  (NARROW_MASK),
        .SPI_FAIL_BIT (SPI_FAIL_BIT)
    ) u_bank (
        .clk          (clk),
        .rst          (rst),
        .smp_valid_i  (smp_valid_i),
        .smp_data_i   (smp_data_i),
        .status_set_i (status_set_i),
        .spi_fail_i   (abort_pulse),
        .wr_stb_i     (wr_stb),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_stb_i     (rd_stb),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .cfg_o        (cfg_o),
        .nd_o         (nd_flag),
        .status_o     (status_word)
    );

    spi_tx_shifter u_tx (
        .clk          (clk),
        .rst          (rst),
        .cs_fall_i    (cs_fall),
        .sclk_fall_i  (sclk_fall),
        .load_word_i  (tx_word),
        .miso_o       (miso_o)
    );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_regport_pkg::*;
#(
    parameter int NUM_OUT      = 4,
    parameter int NUM_CFG      = 4,
    parameter int STAT_WORD    = 8,
    parameter int CFG_BASE     = 16,
    parameter int SPI_FAIL_BIT = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cs_fall,
    input logic                      sclk_fall,
    input logic                      frame_done,
    input logic                      abort_pulse,
    input logic                      wr_stb,
    input logic                      rd_stb,
    input logic [ADDR_W-1:0]         rd_addr,
    input logic                      smp_valid_i,
    input logic                      nd_flag,
    input word_t                     status_word,
    input word_t                     tx_word,
    input logic                      miso_o,
    input logic [NUM_CFG*WORD_W-1:0] cfg_o
);

    region_e rg;
    assign rg = region_of(rd_addr, NUM_OUT, STAT_WORD, CFG_BASE, NUM_CFG);

    // R1: a frame ends either complete or aborted, never both
    assert_single_end_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_done, abort_pulse}));

    // R2: configuration only moves after a write strobe
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(cfg_o));

    // R3: serial output changes only on a falling clock edge
    assert_miso_edge_R3: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(miso_o));

    // R4: each new frame consumes the pending answer
    assert_resp_clear_R4: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (tx_word == '0));

    // R6: new-data flag set by a sample, cleared by an output read
    assert_nd_set_R6: assert property (@(posedge clk) disable iff (rst)
        smp_valid_i |=> nd_flag);
    assert_nd_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (rg == RG_OUT) && !smp_valid_i) |=> !nd_flag);

    // R7: status read clears the word unless new flags arrive
    assert_stat_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (rg == RG_STAT) && !smp_valid_i && !abort_pulse) |=> (status_word == '0));

    // R8: an aborted frame records a link failure and touches nothing
    assert_abort_flag_R8: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |=> status_word[SPI_FAIL_BIT]);
    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> (!wr_stb && !rd_stb));

endmodule

bind spi_regport spi_regport_chk #(
    .NUM_OUT      (NUM_OUT),
    .NUM_CFG      (NUM_CFG),
    .STAT_WORD    (STAT_WORD),
    .CFG_BASE     (CFG_BASE),
    .SPI_FAIL_BIT (SPI_FAIL_BIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_fall      (cs_fall),
    .sclk_fall    (sclk_fall),
    .frame_done   (frame_done),
    .abort_pulse  (abort_pulse),
    .wr_stb       (wr_stb),
    .rd_stb       (rd_stb),
    .rd_addr      (rd_addr),
    .smp_valid_i  (smp_valid_i),
    .nd_flag      (nd_flag),
    .status_word  (status_word),
    .tx_word      (tx_word),
    .miso_o       (miso_o),
    .cfg_o        (cfg_o)
);

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
    import spi_regport_pkg::*;

    localparam int                NUM_OUT   = 4;
    localparam int                NUM_CFG   = 4;
    localparam int                STAT_WORD = 8;
    localparam int                CFG_BASE  = 16;
    localparam logic [NUM_OUT-1:0] NARROW   = 4'b1000;
    localparam int                FAILB     = 3;
    localparam int                H         = 8;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      sclk = 1'b1;
    logic                      cs_n = 1'b1;
    logic                      mosi = 1'b0;
    logic                      miso;
    logic                      smp_valid = 1'b0;
    logic [NUM_OUT*DATA_W-1:0] smp_data = '0;
    logic [15:0]               stat_set = '0;
    logic [NUM_CFG*16-1:0]     cfg;

    always #5 clk = ~clk;

    spi_regport #(
        .NUM_OUT      (NUM_OUT),
        .NUM_CFG      (NUM_CFG),
        .STAT_WORD    (STAT_WORD),
        .CFG_BASE     (CFG_BASE),
        .NARROW_MASK  (NARROW),
        .SPI_FAIL_BIT (FAILB),
        .SYNC_STAGES  (2)
    ) u0 (
        .clk          (clk),
        .rst          (rst),
        .sclk_i       (sclk),
        .cs_n_i       (cs_n),
        .mosi_i       (mosi),
        .miso_o       (miso),
        .smp_valid_i  (smp_valid),
        .smp_data_i   (smp_data),
        .status_set_i (stat_set),
        .cfg_o        (cfg)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    logic [15:0] m_cfg [NUM_CFG];
    logic [13:0] m_out [NUM_OUT];
    logic        m_nd;
    logic [15:0] m_stat;
    logic [15:0] m_resp;
    string       m_tag;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NUM_CFG*16-1:0] m_cfg_flat();
        logic [NUM_CFG*16-1:0] r;
        for (int i = 0; i < NUM_CFG; i++) r[i*16 +: 16] = m_cfg[i];
        return r;
    endfunction

    function automatic logic [15:0] m_read(input logic [5:0] a);
        int w;
        w = int'(a[5:1]);
        if (w < NUM_OUT)
            return {m_nd, |m_stat, NARROW[w] ? {2'b00, m_out[w][11:0]} : m_out[w]};
        if (w == STAT_WORD) return m_stat;
        if (w >= CFG_BASE && w < CFG_BASE + NUM_CFG) return m_cfg[w - CFG_BASE];
        return 16'h0000;
    endfunction

    function automatic string read_tag(input logic [5:0] a);
        int w;
        w = int'(a[5:1]);
        if (w < NUM_OUT) return "R5/R6";
        if (w == STAT_WORD) return "R7";
        if (w >= CFG_BASE && w < CFG_BASE + NUM_CFG) return "R3";
        return "R9";
    endfunction

    function automatic logic [15:0] wr_cmd(input logic [5:0] a, input logic [7:0] d);
        return {1'b1, 1'b0, a, d};
    endfunction

    // junk in the ignored bit and the data bits of a read (R1)
    function automatic logic [15:0] rd_cmd(input logic [5:0] a, input logic [8:0] junk);
        return {1'b0, junk[8], a, junk[7:0]};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = tx[15-i];
            wait_clk(H);
            rx[15-i] = miso;
            sclk = 1'b1;
            wait_clk(H);
        end
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(3*H);
    endtask

    task automatic spi_op(input logic [15:0] tx, input string tag);
        logic [15:0] rx;
        int w;
        xfer(tx, 16, rx);
        check(m_tag, rx, m_resp);
        w = int'(tx[13:9]);
        if (tx[15]) begin
            if (w >= CFG_BASE && w < CFG_BASE + NUM_CFG) begin
                if (tx[8]) m_cfg[w - CFG_BASE][15:8] = tx[7:0];
                else       m_cfg[w - CFG_BASE][7:0]  = tx[7:0];
            end
            m_resp = 16'h0000;
            m_tag  = "R4";
            check("R1/R2/R9", cfg, m_cfg_flat());
        end else begin
            m_resp = m_read(tx[13:8]);
            m_tag  = tag;
            if (w < NUM_OUT)    m_nd = 1'b0;
            if (w == STAT_WORD) m_stat = 16'h0000;
        end
    endtask

    task automatic spi_abort(input logic [15:0] tx, input int nbits);
        logic [15:0] rx;
        xfer(tx, nbits, rx);
        if (nbits > 0) check("R3/R8 partial", rx >> (16 - nbits), m_resp >> (16 - nbits));
        m_stat[FAILB] = 1'b1;
        m_resp = 16'h0000;
        m_tag  = "R4/R8";
        check("R8 no write", cfg, m_cfg_flat());
    endtask

    task automatic sample(input logic [NUM_OUT*DATA_W-1:0] d, input logic [15:0] s);
        @(negedge clk);
        smp_data  = d;
        stat_set  = s;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        stat_set  = '0;
        for (int i = 0; i < NUM_OUT; i++) m_out[i] = d[i*DATA_W +: DATA_W];
        m_nd   = 1'b1;
        m_stat = m_stat | s;
    endtask

    function automatic logic [NUM_OUT*DATA_W-1:0] rnd_data();
        logic [NUM_OUT*DATA_W-1:0] r;
        for (int i = 0; i < NUM_OUT; i++) r[i*DATA_W +: DATA_W] = DATA_W'($urandom);
        return r;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_CFG; i++) m_cfg[i] = '0;
        for (int i = 0; i < NUM_OUT; i++) m_out[i] = '0;
        m_nd = 1'b0; m_stat = '0; m_resp = '0; m_tag = "R4/R10";

        wait_clk(6);
        rst = 1'b0;
        wait_clk(4);
        check("R10 miso", miso, 1'b0);
        check("R10 cfg", cfg, '0);

        // first read after reset: flags and data still at reset values
        spi_op(rd_cmd(6'h00, 9'h0), "R10/R5");
        sample(rnd_data() | {2'b11, {(NUM_OUT*DATA_W-2){1'b0}}}, 16'h0001);
        spi_op(rd_cmd(6'h07, 9'h1A5), "R3/R5");   // odd address, narrow word
        spi_op(rd_cmd(6'h02, 9'h0), "R6");        // new-data already cleared
        spi_op(wr_cmd(6'h20, 8'hA5), "R2");
        spi_op(wr_cmd(6'h21, 8'h3C), "R2");
        spi_op(wr_cmd(6'h27, 8'h99), "R2");
        spi_op(rd_cmd(6'h21, 9'h0FF), "R3");
        spi_op(rd_cmd(6'h10, 9'h0), "R7");
        spi_op(rd_cmd(6'h11, 9'h0), "R7");        // cleared on previous read
        spi_op(wr_cmd(6'h00, 8'hFF), "R9");
        spi_op(wr_cmd(6'h10, 8'hFF), "R9");
        spi_op(wr_cmd(6'h3F, 8'h55), "R9");
        spi_op(rd_cmd(6'h00, 9'h0), "R9");
        spi_op(rd_cmd(6'h3E, 9'h0), "R9");
        spi_op(rd_cmd(6'h22, 9'h0), "R3");
        spi_abort(wr_cmd(6'h22, 8'h77), 15);
        spi_abort(rd_cmd(6'h20, 9'h0), 0);
        spi_op(rd_cmd(6'h10, 9'h0), "R8");
        spi_op(rd_cmd(6'h04, 9'h0), "R5");

        for (int k = 0; k < 160; k++) begin
            int op;
            logic [5:0] a;
            op = int'($urandom_range(0, 9));
            a  = 6'($urandom_range(0, 63));
            if (op <= 2) begin
                if ($urandom_range(0, 1) == 1) a = 6'(32 + $urandom_range(0, 2*NUM_CFG - 1));
                spi_op(wr_cmd(a, 8'($urandom)), "R2");
            end else if (op <= 6) begin
                if ($urandom_range(0, 1) == 1) a = 6'($urandom_range(0, 2*NUM_OUT - 1));
                spi_op(rd_cmd(a, 9'($urandom)), read_tag(a));
            end else if (op == 7) begin
                sample(rnd_data(), 16'($urandom & $urandom & $urandom));
            end else if (op == 8) begin
                spi_abort(16'($urandom), int'($urandom_range(0, 15)));
            end else begin
                spi_op(rd_cmd(6'h10, 9'($urandom)), "R7");
            end
        end
        spi_op(rd_cmd(6'h00, 9'h0), "R5");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule